// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block management instruction (zero a block, clean or flush a block, invalidate a block) may run at the hart's present privilege level. It gets the privilege, a flag that says whether the hart runs as a virtualized guest, and the operation kind. It also gets three enable vectors, one from each environment-configuration level: machine, hypervisor and supervisor. The operation kind selects the same bit position in all three vectors. The block returns either a permission grant or exactly one exception with its cause code.

The enable bits are tested as a cascade in fixed priority. The machine level is tested first, then the hypervisor level for virtualized guests, then the supervisor level for user code. A denial at the machine level, or at the supervisor level outside virtualization, is an illegal-instruction fault. A denial that arises only because the hart runs as a guest is a virtual-instruction fault. Each request is marked by a valid strobe, and its verdict appears on the registered outputs one clock later.

Top module: `cbo_perm_check`

## Requirements
- R1: While reset is active, and on the first cycle after it, the outputs `rsp_valid`, `rsp_allow`, `rsp_fault` and `rsp_cause` are all zero.
- R2: `rsp_valid` equals `req_valid` of the previous clock cycle. A request is answered exactly one cycle after it is presented.
- R3: Privilege M (encoding 2'b11) is always granted, whatever the enable bits, the virtualization flag or the operation code.
- R4: For privilege U (2'b00) or S (2'b01) with a known operation, a clear machine-level bit gives an illegal-instruction fault (cause 2). This holds even when other levels would also deny the request.
- R5: A virtualized request at privilege U or S, with the machine bit set and the hypervisor bit clear, gives a virtual-instruction fault (cause 22).
- R6: A virtualized request at privilege U, with the machine and hypervisor bits set and the supervisor bit clear, gives a virtual-instruction fault (cause 22).
- R7: A non-virtualized request at privilege U, with the machine bit set and the supervisor bit clear, gives an illegal-instruction fault (cause 2). The hypervisor bit has no effect on it.
- R8: A non-virtualized request at privilege S with the machine bit set is granted, whatever the hypervisor and supervisor bits.
- R9: Operation code 0 (zero) uses bit 0 of each enable vector, code 1 (clean/flush) uses bit 1 and code 2 (invalidate) uses bit 2. The bits of the other operations have no effect on the verdict.
- R10: The reserved privilege encoding 2'b10 gives an illegal-instruction fault. So does the reserved operation code 3 at privilege U or S.
- R11: When `rsp_valid` is high, exactly one of `rsp_allow` and `rsp_fault` is high, and `rsp_cause` is 0 on a grant and 2 or 22 on a fault. When `rsp_valid` is low, `rsp_allow` and `rsp_fault` are both low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A permission query is presented this cycle |
| req_priv | input | 2 | Privilege: 00 U, 01 S, 11 M, 10 reserved |
| req_virt | input | 1 | Hart runs as a virtualized guest |
| req_op | input | 2 | Operation: 0 zero, 1 clean/flush, 2 invalidate, 3 reserved |
| cfg_mach_en | input | 3 | Machine-level enable vector, one bit per operation |
| cfg_hyp_en | input | 3 | Hypervisor-level enable vector, one bit per operation |
| cfg_sup_en | input | 3 | Supervisor-level enable vector, one bit per operation |
| rsp_valid | output | 1 | Verdict for the previous cycle's query |
| rsp_allow | output | 1 | Operation permitted |
| rsp_fault | output | 1 | Operation raises an exception |
| rsp_cause | output | 5 | Exception cause: 2 illegal, 22 virtual, 0 on grant |

## Verification
Directed patterns place a single cleared enable bit at each level, under every privilege and virtualization combination. This shows which stage of the cascade fires, and that the two fault kinds are kept apart. Patterns with several bits cleared at once show the priority order: the machine level wins over the hypervisor level, and the hypervisor level wins over the supervisor level. Patterns that clear only the bits of the operations not selected show that the bit is chosen per operation. Random mixes of privilege, virtualization, operation and all three vectors, with idle cycles in between, cover the remaining combinations and the one-cycle response timing.

// File: rtl/cbo_perm_pkg.sv
package cbo_perm_pkg;

    localparam int OP_COUNT  = 3;
    localparam int LVL_COUNT = 3;
    localparam int CAUSE_W   = 5;

    localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = CAUSE_W'(2);
    localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = CAUSE_W'(22);

    // Index of each configuration level inside the packed level array.
    localparam int LVL_MACH = 0;
    localparam int LVL_HYP  = 1;
    localparam int LVL_SUP  = 2;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'b00,
        PRIV_SUPV  = 2'b01,
        PRIV_RSVD  = 2'b10,
        PRIV_MACH  = 2'b11
    } priv_e;

    typedef struct packed {
        logic               valid;
        logic               allow;
        logic               fault;
        logic [CAUSE_W-1:0] cause;
    } verdict_t;

endpackage

// File: rtl/cbo_bit_pick.sv
module cbo_bit_pick #(
    parameter int OPS   = 3,
    parameter int SEL_W = 2
) (
    input  logic [OPS-1:0]   cfg_vec,
    input  logic [SEL_W-1:0] op_sel,
    output logic             bit_out,
    output logic             op_known
);

    // Scan each operation slot; an unmatched code selects nothing.
    always_comb begin
        bit_out  = 1'b0;
        op_known = 1'b0;
        for (int i = 0; i < OPS; i++) begin
            if (op_sel == SEL_W'(i)) begin
                bit_out  = cfg_vec[i];
                op_known = 1'b1;
            end
        end
    end

endmodule

// File: rtl/cbo_perm_rules.sv
module cbo_perm_rules
    import cbo_perm_pkg::*;
(
    input  priv_e              priv,
    input  logic               virt,
    input  logic               op_known,
    input  logic               en_mach,
    input  logic               en_hyp,
    input  logic               en_sup,
    output logic               allow,
    output logic               fault,
    output logic [CAUSE_W-1:0] cause
);

    logic below_m;
    logic is_user;

    assign below_m = (priv == PRIV_USER) || (priv == PRIV_SUPV);
    assign is_user = (priv == PRIV_USER);

    // Fixed-priority cascade: machine, then guest levels, then supervisor.
    always_comb begin
        allow = 1'b0;
        fault = 1'b1;
        cause = CAUSE_ILLEGAL;
        if (priv == PRIV_MACH) begin
            allow = 1'b1;
            fault = 1'b0;
            cause = '0;
        end else if (!below_m || !op_known) begin
            cause = CAUSE_ILLEGAL;
        end else if (!en_mach) begin
            cause = CAUSE_ILLEGAL;
        end else if (virt && !en_hyp) begin
            cause = CAUSE_VIRTUAL;
        end else if (virt && is_user && !en_sup) begin
            cause = CAUSE_VIRTUAL;
        end else if (!virt && is_user && !en_sup) begin
            cause = CAUSE_ILLEGAL;
        end else begin
            allow = 1'b1;
            fault = 1'b0;
            cause = '0;
        end
    end

endmodule

// File: rtl/cbo_perm_check.sv
module cbo_perm_check
    import cbo_perm_pkg::*;
#(
    parameter int OPS   = cbo_perm_pkg::OP_COUNT,
    parameter int SEL_W = $clog2(OPS + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    input  logic [1:0]         req_priv,
    input  logic               req_virt,
    input  logic [SEL_W-1:0]   req_op,
    input  logic [OPS-1:0]     cfg_mach_en,
    input  logic [OPS-1:0]     cfg_hyp_en,
    input  logic [OPS-1:0]     cfg_sup_en,
    output logic               rsp_valid,
    output logic               rsp_allow,
    output logic               rsp_fault,
    output logic [CAUSE_W-1:0] rsp_cause
);

    logic [LVL_COUNT-1:0][OPS-1:0] cfg_all;
    logic [LVL_COUNT-1:0]          lvl_bit;
    logic [LVL_COUNT-1:0]          lvl_known;

    logic               dec_allow;
    logic               dec_fault;
    logic [CAUSE_W-1:0] dec_cause;

    verdict_t state_d;
    verdict_t state_q;

    always_comb begin
        cfg_all           = '0;
        cfg_all[LVL_MACH] = cfg_mach_en;
        cfg_all[LVL_HYP]  = cfg_hyp_en;
        cfg_all[LVL_SUP]  = cfg_sup_en;
    end

    // One selector per configuration level, all steered by the same code.
    for (genvar g = 0; g < LVL_COUNT; g++) begin : g_level
        cbo_bit_pick #(
            .OPS   (OPS),
            .SEL_W (SEL_W)
        ) u_pick (
            .cfg_vec  (cfg_all[g]),
            .op_sel   (req_op),
            .bit_out  (lvl_bit[g]),
            .op_known (lvl_known[g])
        );
    end

    cbo_perm_rules u_rules (
        .priv     (priv_e'(req_priv)),
        .virt     (req_virt),
        .op_known (lvl_known[LVL_MACH]),
        .en_mach  (lvl_bit[LVL_MACH]),
        .en_hyp   (lvl_bit[LVL_HYP]),
        .en_sup   (lvl_bit[LVL_SUP]),
        .allow    (dec_allow),
        .fault    (dec_fault),
        .cause    (dec_cause)
    );

    always_comb begin
        state_d       = '0;
        state_d.valid = req_valid;
        if (req_valid) begin
            state_d.allow = dec_allow;
            state_d.fault = dec_fault;
            state_d.cause = dec_cause;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign rsp_valid = state_q.valid;
    assign rsp_allow = state_q.allow;
    assign rsp_fault = state_q.fault;
    assign rsp_cause = state_q.cause;

endmodule

// File: rtl/cbo_perm_check_sva.sv
module cbo_perm_check_sva
    import cbo_perm_pkg::*;
#(
    parameter int OPS   = 3,
    parameter int SEL_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic [1:0]         req_priv,
    input logic               req_virt,
    input logic [SEL_W-1:0]   req_op,
    input logic [OPS-1:0]     cfg_mach_en,
    input logic [OPS-1:0]     cfg_hyp_en,
    input logic [OPS-1:0]     cfg_sup_en,
    input logic               rsp_valid,
    input logic               rsp_allow,
    input logic               rsp_fault,
    input logic [CAUSE_W-1:0] rsp_cause
);

    logic op_ok;
    logic m_sel;
    logic s_sel;
    logic low_priv;

    always_comb begin
        op_ok = 1'b0;
        m_sel = 1'b0;
        s_sel = 1'b0;
        for (int i = 0; i < OPS; i++) begin
            if (req_op == SEL_W'(i)) begin
                op_ok = 1'b1;
                m_sel = cfg_mach_en[i];
                s_sel = cfg_sup_en[i];
            end
        end
    end

    assign low_priv = (req_priv == 2'b00) || (req_priv == 2'b01);

    a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    a_r2_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);

    a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones({rsp_allow, rsp_fault}) == 1));

    a_r11_quiet_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> (!rsp_allow && !rsp_fault));

    a_r11_grant_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_allow |-> (rsp_cause == '0));

    a_r11_fault_cause: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> (rsp_cause == CAUSE_ILLEGAL || rsp_cause == CAUSE_VIRTUAL));

    a_r3_machine_granted: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == 2'b11) |=> rsp_allow);

    a_r4_machine_bit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && low_priv && op_ok && !m_sel)
        |=> (rsp_fault && rsp_cause == CAUSE_ILLEGAL));

    a_r7_user_native_sup: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_virt && req_priv == 2'b00 && op_ok && m_sel && !s_sel)
        |=> (rsp_fault && rsp_cause == CAUSE_ILLEGAL));

    a_r10_reserved_priv: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_priv == 2'b10) |=> (rsp_fault && rsp_cause == CAUSE_ILLEGAL));

endmodule

bind cbo_perm_check cbo_perm_check_sva #(
    .OPS   (OPS),
    .SEL_W (SEL_W)
) u_sva (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_priv    (req_priv),
    .req_virt    (req_virt),
    .req_op      (req_op),
    .cfg_mach_en (cfg_mach_en),
    .cfg_hyp_en  (cfg_hyp_en),
    .cfg_sup_en  (cfg_sup_en),
    .rsp_valid   (rsp_valid),
    .rsp_allow   (rsp_allow),
    .rsp_fault   (rsp_fault),
    .rsp_cause   (rsp_cause)
);

// File: tb/cbo_perm_check_bench.sv
`timescale 1ns/1ps
module cbo_perm_check_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [1:0] req_priv = 2'b00;
    logic       req_virt = 1'b0;
    logic [1:0] req_op = 2'b00;
    logic [2:0] cfg_mach_en = 3'b000;
    logic [2:0] cfg_hyp_en = 3'b000;
    logic [2:0] cfg_sup_en = 3'b000;
    logic       rsp_valid;
    logic       rsp_allow;
    logic       rsp_fault;
    logic [4:0] rsp_cause;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    cbo_perm_check u_cbo_perm_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_valid   (req_valid),
        .req_priv    (req_priv),
        .req_virt    (req_virt),
        .req_op      (req_op),
        .cfg_mach_en (cfg_mach_en),
        .cfg_hyp_en  (cfg_hyp_en),
        .cfg_sup_en  (cfg_sup_en),
        .rsp_valid   (rsp_valid),
        .rsp_allow   (rsp_allow),
        .rsp_fault   (rsp_fault),
        .rsp_cause   (rsp_cause)
    );

    // Which requirement decides the verdict; 0 means a plain grant.
    function automatic int rule_of(logic [1:0] p, logic v, logic [1:0] op,
                                   logic [2:0] m, logic [2:0] h, logic [2:0] s);
        if (p == 2'b11) return 3;
        if (p == 2'b10) return 10;
        if (op == 2'd3) return 10;
        if (!m[op]) return 4;
        if (v && !h[op]) return 5;
        if (v && p == 2'b00 && !s[op]) return 6;
        if (!v && p == 2'b00 && !s[op]) return 7;
        if (!v && p == 2'b01) return 8;
        return 9;
    endfunction

    // Expected {allow, cause}.
    function automatic logic [5:0] expect_of(int rule);
        case (rule)
            4, 7, 10: return {1'b0, 5'd2};
            5, 6:     return {1'b0, 5'd22};
            default:  return {1'b1, 5'd0};
        endcase
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    // Drive a query on a falling edge; its verdict is sampled one cycle later.
    task automatic query(logic [1:0] p, logic v, logic [1:0] op,
                         logic [2:0] m, logic [2:0] h, logic [2:0] s);
        int rule;
        logic [5:0] e;
        string tag;
        rule = rule_of(p, v, op, m, h, s);
        e = expect_of(rule);
        tag = $sformatf("R%0d", rule);
        req_valid = 1'b1; req_priv = p; req_virt = v; req_op = op;
        cfg_mach_en = m; cfg_hyp_en = h; cfg_sup_en = s;
        @(negedge clk);
        check(rsp_valid == 1'b1, "R2", "rsp_valid", int'(rsp_valid), 1);
        check(rsp_allow == e[5] && rsp_fault == !e[5], tag, "allow",
              int'(rsp_allow), int'(e[5]));
        check(rsp_cause == e[4:0], tag, "cause", int'(rsp_cause), int'(e[4:0]));
        req_valid = 1'b0;
    endtask

    task automatic idle_cycle();
        req_valid = 1'b0;
        req_priv = 2'($urandom_range(0, 3));
        @(negedge clk);
        check(!rsp_valid && !rsp_allow && !rsp_fault, "R11", "idle outputs",
              int'({rsp_valid, rsp_allow, rsp_fault}), 0);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0B_5EED));
        // R1: reset holds outputs at zero even with a query driven
        req_valid = 1'b1; req_priv = 2'b11;
        repeat (3) @(negedge clk);
        check(!rsp_valid && !rsp_allow && !rsp_fault && rsp_cause == 0, "R1",
              "reset outputs", int'({rsp_valid, rsp_allow, rsp_fault, rsp_cause}), 0);
        req_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(!rsp_valid && !rsp_allow && !rsp_fault && rsp_cause == 0, "R1",
              "post-reset outputs", int'({rsp_valid, rsp_allow, rsp_fault}), 0);

        // R3: machine mode granted with every bit clear, virtualized or not
        query(2'b11, 1'b0, 2'd0, 3'b000, 3'b000, 3'b000);
        query(2'b11, 1'b1, 2'd3, 3'b000, 3'b000, 3'b000);
        // R4: machine bit clear outranks hypervisor and supervisor denials
        query(2'b00, 1'b1, 2'd1, 3'b101, 3'b000, 3'b000);
        query(2'b01, 1'b0, 2'd2, 3'b011, 3'b111, 3'b111);
        // R5: guest supervisor with hypervisor bit clear
        query(2'b01, 1'b1, 2'd0, 3'b111, 3'b110, 3'b111);
        // R5 before R6: guest user with both lower bits clear
        query(2'b00, 1'b1, 2'd2, 3'b111, 3'b011, 3'b011);
        // R6: guest user with supervisor bit clear
        query(2'b00, 1'b1, 2'd1, 3'b111, 3'b111, 3'b101);
        // R7: native user, supervisor bit clear, hypervisor bit ignored
        query(2'b00, 1'b0, 2'd0, 3'b111, 3'b000, 3'b110);
        query(2'b00, 1'b0, 2'd0, 3'b111, 3'b111, 3'b110);
        // R8: native supervisor ignores hypervisor and supervisor bits
        query(2'b01, 1'b0, 2'd1, 3'b010, 3'b000, 3'b000);
        // R9: only the selected bit matters
        query(2'b00, 1'b1, 2'd2, 3'b100, 3'b100, 3'b100);
        query(2'b00, 1'b1, 2'd0, 3'b110, 3'b111, 3'b111);
        // R10: reserved privilege and reserved operation
        query(2'b10, 1'b0, 2'd0, 3'b111, 3'b111, 3'b111);
        query(2'b01, 1'b0, 2'd3, 3'b111, 3'b111, 3'b111);
        idle_cycle();
        // Back-to-back queries: R2 timing
        query(2'b00, 1'b0, 2'd1, 3'b111, 3'b111, 3'b111);
        query(2'b00, 1'b1, 2'd1, 3'b111, 3'b111, 3'b111);

        for (int k = 0; k < 600; k++) begin
            if ($urandom_range(0, 4) == 0) idle_cycle();
            query(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
                  2'($urandom_range(0, 3)), 3'($urandom_range(0, 7)),
                  3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
        end
        idle_cycle();

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule